// File: doc/BRIEF.md
# Five-State Snooping Coherence Controller

This block keeps the coherence state of a fixed set of line slots in each of several private caches that share one bus. Every cache presents a local request (a read or a write to one line slot) and the block decides whether that request can finish locally or needs a bus transaction. It then updates the requester and every snooping cache in the same cycle. A holder that has the line dirty, exclusive or in the forwarding state answers with data, a dirty holder also raises a writeback strobe, and memory answers only when no cache can. Data arrays, replacement and memory timing live outside the block.

Requests are served one at a time. A round-robin arbiter grants exactly one requesting cache per cycle, and the grant is also the completion strobe for that cache. A request that hits needs no bus traffic, but it still takes a grant slot, so a silent state change never races a snoop to the same line. Besides the usual four states, the block keeps a forwarding state. It marks the single sharer that answers bus reads, so at most one cache ever drives a data response. State codes are I=0, S=1, E=2, M=3, F=4. Bus operation codes are 0 none, 1 read, 2 read-for-ownership, 3 invalidate.

Top module: `mesif_coh_top`

## Requirements
- R1: After reset, and after any later reset, every line slot of every cache is in state I (code 0) and no bus transaction is shown.
- R2: A read to a line in I that no other cache holds puts a read (code 1) on the bus with memory as the data source (mem_rd high, no supplier), and the requester installs the line as E (2).
- R3: A read to a line the requester holds in any valid state completes with no bus transaction and leaves the state unchanged.
- R4: A write to a line held in E moves it to M (3) with no bus transaction; a write to a line already in M also stays silent.
- R5: A bus read that finds the line in M at another cache makes that cache raise the writeback strobe and supply the data, the holder drops to S (1), and the requester installs the line as F (4).
- R6: A bus read that finds the line in E or F at another cache is answered by that cache alone, even when more caches hold the line in S. The holder drops to S and the requester becomes F. At most one supplier exists in any cycle.
- R7: A write to a line held in S or F puts an invalidate (code 3) on the bus with no data transfer and no writeback. Every other copy goes to I and the writer moves to M.
- R8: A write to a line in I puts a read-for-ownership (code 2) on the bus. A holder in M writes back, a holder in M, E or F supplies, and memory supplies when no cache holds the line. Every other copy goes to I and the writer moves to M.
- R9: Exactly one request is granted per cycle, and the grant doubles as the done strobe. The search starts at the cache after the last one granted, and a request is held until its done strobe.
- R10: After every transaction, no line is in M or E at more than one cache, a line in M or E has no other valid copy, and no line is in F at more than one cache.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | NCACHE | Per-cache request pending |
| req_write | input | NCACHE | Per-cache request is a write |
| req_line | input | NCACHE*LW | Per-cache line slot index, cache i at bits [i*LW +: LW] |
| req_done | output | NCACHE | Grant and completion strobe, one cycle, one-hot or zero |
| bus_valid | output | 1 | A bus transaction is shown this cycle |
| bus_op | output | 2 | Bus operation: 1 read, 2 read-for-ownership, 3 invalidate |
| bus_src | output | CW | Cache that issued the transaction |
| bus_line | output | LW | Line slot of the transaction |
| sup_valid | output | 1 | A cache supplies the data |
| sup_src | output | CW | Supplying cache |
| mem_rd | output | 1 | Memory must supply the data |
| wb_valid | output | 1 | A dirty holder writes the line back |
| wb_src | output | CW | Cache that writes back |
| line_state | output | NCACHE*NLINE*3 | State of cache c, slot l at bits [(c*NLINE+l)*3 +: 3] |

## Verification
The hardest case to reach is a bus read that finds a line held by one forwarding cache and one plain sharer. Only the forwarding cache may answer, and the forwarding role must move to the requester. Getting there takes a chain of traffic to one line: a silent upgrade to M, a read from a second cache that forces a writeback, then a read from a third cache. The stimulus table walks that chain in order. It then upgrades a sharer and takes ownership from a dirty holder. Between transactions the bench checks every line for duplicate owners and forwarders. A final burst of three simultaneous hits shows the rotation of the arbiter.

// File: rtl/mesif_pkg.sv
package mesif_pkg;
  typedef enum logic [2:0] {
    ST_I = 3'd0,
    ST_S = 3'd1,
    ST_E = 3'd2,
    ST_M = 3'd3,
    ST_F = 3'd4
  } mesif_t;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_RD   = 2'd1,
    OP_RFO  = 2'd2,
    OP_UPG  = 2'd3
  } bus_op_t;

  localparam int ST_W = 3;
endpackage

// File: rtl/mesif_rr_arb.sv
module mesif_rr_arb #(
  parameter int N  = 3,
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic [CW-1:0] gnt_id,
  output logic          gnt_any
);
  logic [CW-1:0] ptr_q, ptr_d;
  logic          ptr_en;

  always_comb begin
    gnt     = '0;
    gnt_id  = '0;
    gnt_any = 1'b0;
    for (int off = 0; off < N; off++) begin
      int idx;
      idx = (int'(ptr_q) + off) % N;
      if (!gnt_any && req[idx]) begin
        gnt_any  = 1'b1;
        gnt_id   = CW'(idx);
        gnt[idx] = 1'b1;
      end
    end
    ptr_en = gnt_any;
    ptr_d  = (int'(gnt_id) == N - 1) ? '0 : gnt_id + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end
endmodule

// File: rtl/mesif_cache_ctl.sv
module mesif_cache_ctl
  import mesif_pkg::*;
#(
  parameter int NLINE = 4,
  parameter int LW    = 2,
  parameter int CW    = 2,
  parameter int ID    = 0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  grant,
  input  logic                  req_write,
  input  logic [LW-1:0]         req_line,
  input  logic                  others_hold,
  input  logic                  bus_valid,
  input  logic [1:0]            bus_op,
  input  logic [LW-1:0]         bus_line,
  input  logic [CW-1:0]         bus_src,
  output logic [1:0]            need_op,
  output logic                  snoop_hit,
  output logic                  snoop_sup,
  output logic                  snoop_wb,
  output logic [NLINE*ST_W-1:0] states
);
  localparam logic [CW-1:0] MY_ID = CW'(ID);

  mesif_t st_q [NLINE];
  mesif_t st_d [NLINE];
  mesif_t own_st, snp_st;
  logic   snoop_v, data_op, upd_en;

  always_comb begin
    own_st = st_q[req_line];
    if (req_write)
      need_op = (own_st == ST_I) ? OP_RFO :
                ((own_st == ST_S || own_st == ST_F) ? OP_UPG : OP_NONE);
    else
      need_op = (own_st == ST_I) ? OP_RD : OP_NONE;

    snoop_v   = bus_valid && (bus_src != MY_ID);
    snp_st    = st_q[bus_line];
    data_op   = (bus_op == OP_RD) || (bus_op == OP_RFO);
    snoop_hit = snoop_v && (snp_st != ST_I);
    snoop_sup = snoop_v && data_op &&
                (snp_st == ST_M || snp_st == ST_E || snp_st == ST_F);
    snoop_wb  = snoop_v && data_op && (snp_st == ST_M);
  end

  always_comb begin
    upd_en = grant || snoop_v;
    for (int l = 0; l < NLINE; l++) begin
      st_d[l] = st_q[l];
      if (snoop_v && (int'(bus_line) == l)) begin
        if (bus_op == OP_RD) begin
          if (st_q[l] != ST_I) st_d[l] = ST_S;
        end else begin
          st_d[l] = ST_I;
        end
      end
      if (grant && (int'(req_line) == l)) begin
        if (req_write)             st_d[l] = ST_M;
        else if (st_q[l] == ST_I)  st_d[l] = others_hold ? ST_F : ST_E;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int l = 0; l < NLINE; l++) st_q[l] <= ST_I;
    end else if (upd_en) begin
      for (int l = 0; l < NLINE; l++) st_q[l] <= st_d[l];
    end
  end

  always_comb begin
    for (int l = 0; l < NLINE; l++) states[l*ST_W +: ST_W] = st_q[l];
  end
endmodule

// File: rtl/mesif_coh_top.sv
module mesif_coh_top
  import mesif_pkg::*;
#(
  parameter int NCACHE = 3,
  parameter int NLINE  = 4,
  localparam int CW = (NCACHE > 1) ? $clog2(NCACHE) : 1,
  localparam int LW = (NLINE > 1) ? $clog2(NLINE) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NCACHE-1:0]           req_valid,
  input  logic [NCACHE-1:0]           req_write,
  input  logic [NCACHE*LW-1:0]        req_line,
  output logic [NCACHE-1:0]           req_done,
  output logic                        bus_valid,
  output logic [1:0]                  bus_op,
  output logic [CW-1:0]               bus_src,
  output logic [LW-1:0]               bus_line,
  output logic                        sup_valid,
  output logic [CW-1:0]               sup_src,
  output logic                        mem_rd,
  output logic                        wb_valid,
  output logic [CW-1:0]               wb_src,
  output logic [NCACHE*NLINE*3-1:0]   line_state
);
  localparam int SLICE = NLINE * ST_W;

  logic [1:0]    rsync_q;
  logic          rst_int_n;
  logic [NCACHE-1:0] gnt_vec, hit_vec, sup_vec, wb_vec;
  logic [CW-1:0] gnt_id;
  logic          gnt_any, others_hold;
  logic [1:0]    need_op  [NCACHE];
  logic [LW-1:0] line_arr [NCACHE];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  mesif_rr_arb #(.N(NCACHE), .CW(CW)) u_arb (
    .clk(clk), .rst_n(rst_int_n), .req(req_valid),
    .gnt(gnt_vec), .gnt_id(gnt_id), .gnt_any(gnt_any)
  );

  always_comb begin
    bus_op    = gnt_any ? need_op[gnt_id] : OP_NONE;
    bus_valid = (bus_op != OP_NONE);
    bus_src   = gnt_id;
    bus_line  = line_arr[gnt_id];
    others_hold = |hit_vec;
    sup_valid = |sup_vec;
    wb_valid  = |wb_vec;
    mem_rd    = bus_valid && (bus_op != OP_UPG) && !sup_valid;
    sup_src   = '0;
    wb_src    = '0;
    for (int i = 0; i < NCACHE; i++) begin
      if (sup_vec[i]) sup_src = CW'(i);
      if (wb_vec[i])  wb_src  = CW'(i);
    end
  end
  assign req_done = gnt_vec;

  for (genvar i = 0; i < NCACHE; i++) begin : g_cache
    assign line_arr[i] = req_line[i*LW +: LW];
    mesif_cache_ctl #(.NLINE(NLINE), .LW(LW), .CW(CW), .ID(i)) u_ctl (
      .clk(clk), .rst_n(rst_int_n), .grant(gnt_vec[i]),
      .req_write(req_write[i]), .req_line(line_arr[i]),
      .others_hold(others_hold), .bus_valid(bus_valid), .bus_op(bus_op),
      .bus_line(bus_line), .bus_src(bus_src), .need_op(need_op[i]),
      .snoop_hit(hit_vec[i]), .snoop_sup(sup_vec[i]), .snoop_wb(wb_vec[i]),
      .states(line_state[i*SLICE +: SLICE])
    );
  end
endmodule

// File: rtl/mesif_coh_chk.sv
module mesif_coh_chk #(
  parameter int NCACHE = 3,
  parameter int NLINE  = 4,
  parameter int CW     = 2,
  parameter int LW     = 2
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      bus_valid,
  input logic [1:0]                bus_op,
  input logic [CW-1:0]             bus_src,
  input logic [LW-1:0]             bus_line,
  input logic                      mem_rd,
  input logic                      wb_valid,
  input logic [NCACHE-1:0]         sup_vec,
  input logic [NCACHE-1:0]         gnt_vec,
  input logic [NCACHE*NLINE*3-1:0] line_state
);
  localparam int IW = $clog2(NCACHE * NLINE) + 1;

  logic          upg_q;
  logic [IW-1:0] upg_idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upg_q     <= 1'b0;
      upg_idx_q <= '0;
    end else begin
      upg_q     <= bus_valid && (bus_op == 2'd3);
      upg_idx_q <= IW'(int'(bus_src) * NLINE + int'(bus_line));
    end
  end

  // R6
  one_sup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sup_vec));

  // R9
  one_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_vec));

  // R8
  wb_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (bus_valid && bus_op != 2'd3));

  // R7
  upg_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_op == 2'd3) |-> (!mem_rd && !wb_valid && sup_vec == '0));

  // R7
  upg_own_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upg_q |-> (line_state[upg_idx_q*3 +: 3] == 3'd3));

  for (genvar l = 0; l < NLINE; l++) begin : g_line
    logic [NCACHE-1:0] own_v, fwd_v;
    always_comb begin
      for (int c = 0; c < NCACHE; c++) begin
        own_v[c] = (line_state[(c*NLINE+l)*3 +: 3] == 3'd2) ||
                   (line_state[(c*NLINE+l)*3 +: 3] == 3'd3);
        fwd_v[c] = (line_state[(c*NLINE+l)*3 +: 3] == 3'd4);
      end
    end
    // R10
    own_uniq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(own_v));
    // R10
    fwd_uniq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(fwd_v));
  end
endmodule

bind mesif_coh_top mesif_coh_chk #(
  .NCACHE(NCACHE), .NLINE(NLINE), .CW(CW), .LW(LW)
) u_chk (
  .clk(clk), .rst_n(rst_int_n), .bus_valid(bus_valid), .bus_op(bus_op),
  .bus_src(bus_src), .bus_line(bus_line), .mem_rd(mem_rd),
  .wb_valid(wb_valid), .sup_vec(sup_vec), .gnt_vec(gnt_vec),
  .line_state(line_state)
);

// File: tb/sim_mesif_coh_top.sv
`timescale 1ns/1ps
module sim_mesif_coh_top;
  localparam int N  = 3;
  localparam int NL = 4;
  localparam int CW = 2;
  localparam int LW = 2;
  localparam int NV = 13;

  logic clk, rst_n;
  logic [N-1:0]    req_valid, req_write, req_done;
  logic [N*LW-1:0] req_line;
  logic bus_valid, sup_valid, mem_rd, wb_valid;
  logic [1:0]    bus_op;
  logic [CW-1:0] bus_src, sup_src, wb_src;
  logic [LW-1:0] bus_line;
  logic [N*NL*3-1:0] line_state;

  int total = 0;
  int bad   = 0;

  mesif_coh_top #(.NCACHE(N), .NLINE(NL)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_line(req_line), .req_done(req_done), .bus_valid(bus_valid),
    .bus_op(bus_op), .bus_src(bus_src), .bus_line(bus_line),
    .sup_valid(sup_valid), .sup_src(sup_src), .mem_rd(mem_rd),
    .wb_valid(wb_valid), .wb_src(wb_src), .line_state(line_state)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // {cache, wr, line, op, mem, wb, supv, supid, req_state, other_cache, other_state}
  localparam logic [19:0] VEC [NV] = '{
    {2'd0,1'b0,2'd0,2'd1,1'b1,1'b0,1'b0,2'd0,3'd2,2'd1,3'd0},
    {2'd0,1'b0,2'd0,2'd0,1'b0,1'b0,1'b0,2'd0,3'd2,2'd1,3'd0},
    {2'd0,1'b1,2'd0,2'd0,1'b0,1'b0,1'b0,2'd0,3'd3,2'd1,3'd0},
    {2'd1,1'b0,2'd0,2'd1,1'b0,1'b1,1'b1,2'd0,3'd4,2'd0,3'd1},
    {2'd2,1'b0,2'd0,2'd1,1'b0,1'b0,1'b1,2'd1,3'd4,2'd1,3'd1},
    {2'd1,1'b1,2'd0,2'd3,1'b0,1'b0,1'b0,2'd0,3'd3,2'd2,3'd0},
    {2'd2,1'b1,2'd0,2'd2,1'b0,1'b1,1'b1,2'd1,3'd3,2'd1,3'd0},
    {2'd0,1'b0,2'd1,2'd1,1'b1,1'b0,1'b0,2'd0,3'd2,2'd1,3'd0},
    {2'd1,1'b0,2'd1,2'd1,1'b0,1'b0,1'b1,2'd0,3'd4,2'd0,3'd1},
    {2'd2,1'b1,2'd2,2'd2,1'b1,1'b0,1'b0,2'd0,3'd3,2'd0,3'd0},
    {2'd0,1'b1,2'd1,2'd3,1'b0,1'b0,1'b0,2'd0,3'd3,2'd1,3'd0},
    {2'd1,1'b0,2'd3,2'd1,1'b1,1'b0,1'b0,2'd0,3'd2,2'd0,3'd0},
    {2'd1,1'b1,2'd3,2'd0,1'b0,1'b0,1'b0,2'd0,3'd3,2'd0,3'd0}
  };

  function automatic string tag_of(int k);
    case (k)
      0, 7, 11: return "R2";
      1:        return "R3";
      2, 12:    return "R4";
      3:        return "R5";
      4, 8:     return "R6";
      5, 10:    return "R7";
      default:  return "R8";
    endcase
  endfunction

  function automatic logic [2:0] st(int c, int l);
    return line_state[(c*NL+l)*3 +: 3];
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic check_inv();
    int err = 0;
    for (int l = 0; l < NL; l++) begin
      int own = 0, fwd = 0, vld = 0;
      for (int c = 0; c < N; c++) begin
        if (st(c,l) == 3'd2 || st(c,l) == 3'd3) own++;
        if (st(c,l) == 3'd4) fwd++;
        if (st(c,l) != 3'd0) vld++;
      end
      if (own > 1 || fwd > 1 || (own == 1 && vld > 1)) err++;
    end
    chk("R10", "lines breaking ownership rules", err, 0);
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    summary();
  end

  initial begin
    req_valid = '0; req_write = '0; req_line = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk("R1", "states after reset", int'(|line_state), 0);
    chk("R1", "bus idle after reset", int'(bus_valid), 0);

    for (int k = 0; k < NV; k++) begin
      logic [19:0] v;
      int c, ln, wait_n;
      v  = VEC[k];
      c  = int'(v[19:18]);
      ln = int'(v[16:15]);
      @(negedge clk);
      req_valid[c] = 1'b1;
      req_write[c] = v[17];
      req_line[c*LW +: LW] = v[16:15];
      #1;
      wait_n = 0;
      while (!req_done[c] && wait_n < 50) begin
        @(negedge clk); #1; wait_n++;
      end
      chk(tag_of(k), "done strobe", int'(req_done[c]), 1);
      chk(tag_of(k), "bus op", int'(bus_op), int'(v[14:13]));
      chk(tag_of(k), "memory supply", int'(mem_rd), int'(v[12]));
      chk(tag_of(k), "writeback", int'(wb_valid), int'(v[11]));
      chk(tag_of(k), "cache supply", int'(sup_valid), int'(v[10]));
      if (v[10]) chk(tag_of(k), "supplier id", int'(sup_src), int'(v[9:8]));
      if (v[11]) chk(tag_of(k), "writeback id", int'(wb_src), int'(v[9:8]));
      @(posedge clk); #1;
      req_valid[c] = 1'b0;
      @(negedge clk); #1;
      chk(tag_of(k), "requester state", int'(st(c, ln)), int'(v[7:5]));
      chk(tag_of(k), "other cache state", int'(st(int'(v[4:3]), ln)), int'(v[2:0]));
      check_inv();
    end

    // R9: three hits at once; last grant went to cache 1, so order is 2, 0, 1
    @(negedge clk);
    req_write = '0;
    req_line  = {2'd2, 2'd3, 2'd1};
    req_valid = 3'b111;
    for (int s = 0; s < 3; s++) begin
      int exp_c;
      exp_c = (s == 0) ? 2 : ((s == 1) ? 0 : 1);
      #1;
      chk("R9", "grant vector", int'(req_done), 1 << exp_c);
      chk("R3", "hit stays off the bus", int'(bus_valid), 0);
      @(posedge clk); #1;
      req_valid[exp_c] = 1'b0;
      @(negedge clk);
    end
    #1;
    chk("R3", "hit keeps state M", int'(st(0,1)), 3);
    chk("R9", "no grant when idle", int'(req_done), 0);

    // R1: reset in the middle of traffic clears everything
    rst_n = 1'b0;
    @(negedge clk); #1;
    chk("R1", "states after second reset", int'(|line_state), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "bus idle after second reset", int'(bus_valid), 0);
    summary();
  end
endmodule